// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Unit

This unit sits between an interrupt arbiter and the processors that an interrupt controller serves. For each processor it keeps the identity and priority of the interrupt now being serviced. When a processor acknowledges, the arbiter supplies that processor's best pending identifier. The unit grants it only when its priority is strictly better (numerically lower) than the running priority. On a grant it pushes the interrupt onto a per-processor nesting chain and asks the pending logic to clear the source. If there is no grant, it answers with the no-interrupt code 1023.

Completion is done by an end-of-interrupt write. The write usually names the innermost interrupt, which is popped so that the preempted one resumes with its own priority. It may instead name an interrupt deeper in the nest. The unit then walks the chain of predecessors one table entry per clock and splices that entry out, and it reports itself busy while it does so. A completed source that is level-sensitive, enabled, still asserted and aimed at the completing processor is handed back to the pending logic so that it becomes pending again.

When an acknowledge and a completion arrive in the same cycle, the acknowledge is served and the completion is dropped. Priorities come from an external combinational lookup that is addressed by the unit.

Top module: `nic_ack_eoi_unit`

## Requirements
- R1: An acknowledge answers `ack_id` = 1023 and leaves the running state unchanged when `hp_id` is not below NUM_IRQ (1023 included), or when the priority of `hp_id` is not strictly below the running priority of that processor.
- R2: A granted acknowledge pulses `ack_vld` with `ack_id` = `hp_id` in the cycle after the request, and from then on `run_id` and `run_prio` of that processor show the new ID and its looked-up priority.
- R3: A granted acknowledge pulses `clr_vld` for one cycle with `clr_id` = the granted ID. `clr_mask` has every processor bit set when `hp_one_of_n` is 1, and only bit `ack_cpu` set when it is 0.
- R4: After reset, and whenever nothing is running, a processor shows `run_id` = 1023 and `run_prio` = 0x100. An end-of-interrupt that arrives in that state changes nothing and requests no re-pend.
- R5: An end-of-interrupt for ID k pulses `set_vld` with `set_id` = k and only bit `eoi_cpu` of `set_mask` set, exactly when `irq_edge[k]`=0, `irq_en[k]`=1, `irq_lvl[k]`=1 and `irq_tgt[k*NUM_CPU+eoi_cpu]`=1.
- R6: An end-of-interrupt naming the running ID makes the running ID its stored predecessor, one cycle later. The running priority becomes the priority of that predecessor, or 0x100 when the predecessor is 1023.
- R7: An end-of-interrupt naming a non-running ID that is in the nest removes that ID from the chain and leaves the order of all other entries unchanged. A non-running ID at or above NUM_IRQ changes nothing.
- R8: The completed ID is taken from `eoi_data[9:0]`. Bits 31:10 have no effect.
- R9: While a chain walk is in progress `busy` is 1, and acknowledge and end-of-interrupt requests are ignored: there is no `ack_vld` and no change of any running state.
- R10: Each processor has its own running state and its own chain. Requests for one processor never alter the running state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | Processor issuing the acknowledge |
| hp_id | input | 10 | Highest-pending ID for that processor, 1023 if none |
| hp_one_of_n | input | 1 | Source of hp_id is delivered to one of N processors |
| ack_vld | output | 1 | Acknowledge answer valid |
| ack_id | output | 10 | Granted ID or 1023 |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | CPU_W | Processor issuing the completion |
| eoi_data | input | 32 | Written completion word, ID in bits 9:0 |
| irq_edge | input | NUM_IRQ | Per-source edge-sensitive flag |
| irq_en | input | NUM_IRQ | Per-source enable |
| irq_lvl | input | NUM_IRQ | Per-source current input level |
| irq_tgt | input | NUM_IRQ*NUM_CPU | Target bits, bit k*NUM_CPU+c for source k, processor c |
| prio_id | output | 10 | ID whose priority is looked up |
| prio_cpu | output | CPU_W | Processor for the priority lookup |
| prio_val | input | 8 | Looked-up priority |
| clr_vld | output | 1 | Pending-clear request |
| clr_id | output | 10 | ID to clear |
| clr_mask | output | NUM_CPU | Processors whose pending bit is cleared |
| set_vld | output | 1 | Pending-set (re-pend) request |
| set_id | output | 10 | ID to set pending |
| set_mask | output | NUM_CPU | Processors whose pending bit is set |
| run_id | output | NUM_CPU*10 | Running ID per processor |
| run_prio | output | NUM_CPU*9 | Running priority per processor |
| busy | output | 1 | Chain walk in progress |

## Verification
The hardest case to reach is a completion that names an interrupt buried several levels below the innermost one. The chain then has to be walked while the ports show nothing but `busy`. The bench builds a full nest on one processor, using priorities that fall with rising ID so that every acknowledge preempts. For every possible buried position it completes that one entry and then pops the rest, and it checks that the running ID and priority follow the expected shortened chain. During one long walk it also issues an acknowledge for the other processor to show that the stall holds.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int ID_W    = 10;
    localparam int PRIO_W  = 8;
    localparam int RPRIO_W = 9;
    localparam logic [ID_W-1:0]    NO_IRQ    = 10'd1023;
    localparam logic [RPRIO_W-1:0] IDLE_PRIO = 9'h100;
endpackage

// File: rtl/nic_ack_qualify.sv
module nic_ack_qualify
    import nic_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [ID_W-1:0]    cand_id,
    input  logic [PRIO_W-1:0]  cand_prio,
    input  logic [RPRIO_W-1:0] cur_prio,
    output logic               grant
);
    always_comb begin
        grant = (cand_id < ID_W'(NUM_IRQ)) && ({1'b0, cand_prio} < cur_prio);
    end
endmodule

// File: rtl/nic_repend_sel.sv
module nic_repend_sel
    import nic_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 32,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [ID_W-1:0]            done_id,
    input  logic [CPU_W-1:0]           done_cpu,
    input  logic [NUM_IRQ-1:0]         irq_edge,
    input  logic [NUM_IRQ-1:0]         irq_en,
    input  logic [NUM_IRQ-1:0]         irq_lvl,
    input  logic [NUM_IRQ*NUM_CPU-1:0] irq_tgt,
    output logic                       repend
);
    logic [NUM_CPU-1:0] tgt_row [NUM_IRQ];
    logic [NUM_IRQ-1:0] qualified;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_src
        assign tgt_row[k]   = irq_tgt[k*NUM_CPU +: NUM_CPU];
        assign qualified[k] = !irq_edge[k] && irq_en[k] && irq_lvl[k]
                              && tgt_row[k][done_cpu];
    end

    always_comb begin
        repend = 1'b0;
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (done_id == ID_W'(k)) repend = qualified[k];
        end
    end
endmodule

// File: rtl/nic_ack_eoi_unit.sv
module nic_ack_eoi_unit
    import nic_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 32,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ack_req,
    input  logic [CPU_W-1:0]           ack_cpu,
    input  logic [ID_W-1:0]            hp_id,
    input  logic                       hp_one_of_n,
    output logic                       ack_vld,
    output logic [ID_W-1:0]            ack_id,
    input  logic                       eoi_req,
    input  logic [CPU_W-1:0]           eoi_cpu,
    input  logic [31:0]                eoi_data,
    input  logic [NUM_IRQ-1:0]         irq_edge,
    input  logic [NUM_IRQ-1:0]         irq_en,
    input  logic [NUM_IRQ-1:0]         irq_lvl,
    input  logic [NUM_IRQ*NUM_CPU-1:0] irq_tgt,
    output logic [ID_W-1:0]            prio_id,
    output logic [CPU_W-1:0]           prio_cpu,
    input  logic [PRIO_W-1:0]          prio_val,
    output logic                       clr_vld,
    output logic [ID_W-1:0]            clr_id,
    output logic [NUM_CPU-1:0]         clr_mask,
    output logic                       set_vld,
    output logic [ID_W-1:0]            set_id,
    output logic [NUM_CPU-1:0]         set_mask,
    output logic [NUM_CPU*ID_W-1:0]    run_id,
    output logic [NUM_CPU*RPRIO_W-1:0] run_prio,
    output logic                       busy
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    typedef struct packed {
        logic [NUM_CPU-1:0][ID_W-1:0]              run_id;
        logic [NUM_CPU-1:0][RPRIO_W-1:0]           run_prio;
        logic [NUM_CPU-1:0][NUM_IRQ-1:0][ID_W-1:0] pred;
        logic                                      walking;
        logic [CPU_W-1:0]                          w_cpu;
        logic [ID_W-1:0]                           w_tgt;
        logic [ID_W-1:0]                           w_cur;
        logic                                      ack_vld;
        logic [ID_W-1:0]                           ack_id;
        logic                                      clr_vld;
        logic [ID_W-1:0]                           clr_id;
        logic [NUM_CPU-1:0]                        clr_mask;
        logic                                      set_vld;
        logic [ID_W-1:0]                           set_id;
        logic [NUM_CPU-1:0]                        set_mask;
    } st_t;

    st_t q, d;

    logic [CPU_W-1:0]   req_cpu;
    logic [ID_W-1:0]    cur_run;
    logic [RPRIO_W-1:0] cur_rprio;
    logic [ID_W-1:0]    pred_of_run;
    logic [ID_W-1:0]    done_id;
    logic [ID_W-1:0]    walk_nxt;
    logic               grant;
    logic               repend;
    logic               eoi_unused;

    assign eoi_unused  = ^eoi_data[31:ID_W];
    assign done_id     = eoi_data[ID_W-1:0];
    assign req_cpu     = ack_req ? ack_cpu : eoi_cpu;
    assign cur_run     = q.run_id[req_cpu];
    assign cur_rprio   = q.run_prio[req_cpu];
    assign pred_of_run = q.pred[eoi_cpu][cur_run[IDX_W-1:0]];
    assign walk_nxt    = q.pred[q.w_cpu][q.w_cur[IDX_W-1:0]];
    assign prio_id     = ack_req ? hp_id : pred_of_run;
    assign prio_cpu    = req_cpu;

    nic_ack_qualify #(.NUM_IRQ(NUM_IRQ)) u_qual (
        .cand_id   (hp_id),
        .cand_prio (prio_val),
        .cur_prio  (cur_rprio),
        .grant     (grant)
    );

    nic_repend_sel #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_repend (
        .done_id  (done_id),
        .done_cpu (eoi_cpu),
        .irq_edge (irq_edge),
        .irq_en   (irq_en),
        .irq_lvl  (irq_lvl),
        .irq_tgt  (irq_tgt),
        .repend   (repend)
    );

    always_comb begin
        d         = q;
        d.ack_vld = 1'b0;
        d.clr_vld = 1'b0;
        d.set_vld = 1'b0;
        if (q.walking) begin
            if (walk_nxt == NO_IRQ) begin
                d.walking = 1'b0;
            end else if (walk_nxt == q.w_tgt) begin
                d.pred[q.w_cpu][q.w_cur[IDX_W-1:0]] = q.pred[q.w_cpu][q.w_tgt[IDX_W-1:0]];
                d.walking = 1'b0;
            end else begin
                d.w_cur = walk_nxt;
            end
        end else if (ack_req) begin
            d.ack_vld = 1'b1;
            d.ack_id  = NO_IRQ;
            if (grant) begin
                d.ack_id                            = hp_id;
                d.pred[ack_cpu][hp_id[IDX_W-1:0]]   = cur_run;
                d.run_id[ack_cpu]                   = hp_id;
                d.run_prio[ack_cpu]                 = {1'b0, prio_val};
                d.clr_vld                           = 1'b1;
                d.clr_id                            = hp_id;
                d.clr_mask = hp_one_of_n ? {NUM_CPU{1'b1}} : (NUM_CPU'(1) << ack_cpu);
            end
        end else if (eoi_req && (cur_run != NO_IRQ)) begin
            if (repend) begin
                d.set_vld  = 1'b1;
                d.set_id   = done_id;
                d.set_mask = NUM_CPU'(1) << eoi_cpu;
            end
            if (done_id == cur_run) begin
                d.run_id[eoi_cpu]   = pred_of_run;
                d.run_prio[eoi_cpu] = (pred_of_run == NO_IRQ) ? IDLE_PRIO : {1'b0, prio_val};
            end else if (done_id < ID_W'(NUM_IRQ)) begin
                d.walking = 1'b1;
                d.w_cpu   = eoi_cpu;
                d.w_tgt   = done_id;
                d.w_cur   = cur_run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.run_id <= '1;
            q.pred   <= '1;
            for (int c = 0; c < NUM_CPU; c++) q.run_prio[c] <= IDLE_PRIO;
        end else begin
            q <= d;
        end
    end

    assign ack_vld  = q.ack_vld;
    assign ack_id   = q.ack_id;
    assign clr_vld  = q.clr_vld;
    assign clr_id   = q.clr_id;
    assign clr_mask = q.clr_mask;
    assign set_vld  = q.set_vld;
    assign set_id   = q.set_id;
    assign set_mask = q.set_mask;
    assign run_id   = q.run_id;
    assign run_prio = q.run_prio;
    assign busy     = q.walking;
endmodule

// File: rtl/nic_ack_eoi_unit_chk.sv
module nic_ack_eoi_unit_chk
    import nic_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_IRQ = 32,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ack_req,
    input logic [ID_W-1:0]            hp_id,
    input logic                       ack_vld,
    input logic [ID_W-1:0]            ack_id,
    input logic                       eoi_req,
    input logic [CPU_W-1:0]           eoi_cpu,
    input logic                       clr_vld,
    input logic [NUM_CPU-1:0]         clr_mask,
    input logic                       set_vld,
    input logic [NUM_CPU-1:0]         set_mask,
    input logic [NUM_CPU*ID_W-1:0]    run_id,
    input logic [NUM_CPU*RPRIO_W-1:0] run_prio,
    input logic                       busy
);
    a_r1_nothing_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ack_req && hp_id == NO_IRQ) |=> (ack_vld && ack_id == NO_IRQ));

    a_r9_busy_stalls_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ack_req) |=> !ack_vld);

    a_r4_idle_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id[ID_W-1:0] == NO_IRQ) |-> (run_prio[RPRIO_W-1:0] == IDLE_PRIO));

    a_r4_idle_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ack_req && eoi_req && eoi_cpu == '0 && run_id[ID_W-1:0] == NO_IRQ)
        |=> (!set_vld && run_id[ID_W-1:0] == NO_IRQ));

    a_r3_clear_has_target: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vld |-> (clr_mask != '0));

    a_r5_repend_one_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |-> ($countones(set_mask) == 1));
endmodule

bind nic_ack_eoi_unit nic_ack_eoi_unit_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (.*);

// File: tb/nic_ack_eoi_unit_bench.sv
`timescale 1ns/1ps
module nic_ack_eoi_unit_bench;
    localparam int NC = 2;
    localparam int NI = 8;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_req = 1'b0;
    logic [0:0] ack_cpu = '0;
    logic [9:0] hp_id = 10'd1023;
    logic hp_one_of_n = 1'b0;
    logic ack_vld;
    logic [9:0] ack_id;
    logic eoi_req = 1'b0;
    logic [0:0] eoi_cpu = '0;
    logic [31:0] eoi_data = '0;
    logic [NI-1:0] irq_edge = '0, irq_en = '0, irq_lvl = '0;
    logic [NI*NC-1:0] irq_tgt = '0;
    logic [9:0] prio_id;
    logic [0:0] prio_cpu;
    logic [7:0] prio_val;
    logic clr_vld, set_vld, busy;
    logic [9:0] clr_id, set_id;
    logic [NC-1:0] clr_mask, set_mask;
    logic [NC*10-1:0] run_id;
    logic [NC*9-1:0] run_prio;

    int errors = 0;
    int checks = 0;
    int mrun [NC];
    int mpred [NC][NI];

    always #2 clk = ~clk;

    function automatic int pr(int cpu, int id);
        return (id < NI) ? (200 - 16 * id - cpu) : 0;
    endfunction

    assign prio_val = 8'(pr(int'(prio_cpu), int'(prio_id)));

    nic_ack_eoi_unit #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_nic_ack_eoi_unit (.*);

    function automatic int exp_rprio(int cpu);
        return (mrun[cpu] == NONE) ? 256 : pr(cpu, mrun[cpu]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_run(input int cpu, input string req);
        check(int'(run_id[cpu*10 +: 10]) == mrun[cpu], req, int'(run_id[cpu*10 +: 10]), mrun[cpu]);
        check(int'(run_prio[cpu*9 +: 9]) == exp_rprio(cpu), req, int'(run_prio[cpu*9 +: 9]), exp_rprio(cpu));
    endtask

    task automatic do_ack(input int cpu, input int hp, input bit one_of_n, input string req);
        bit g;
        int m;
        g = (hp < NI) && (pr(cpu, hp) < exp_rprio(cpu));
        ack_req = 1'b1; ack_cpu = 1'(cpu); hp_id = 10'(hp); hp_one_of_n = one_of_n;
        @(posedge clk); #1;
        check(ack_vld == 1'b1, req, int'(ack_vld), 1);
        check(int'(ack_id) == (g ? hp : NONE), req, int'(ack_id), g ? hp : NONE);
        check(clr_vld == g, "R3", int'(clr_vld), int'(g));
        if (g) begin
            m = one_of_n ? 3 : (1 << cpu);
            check(int'(clr_mask) == m && int'(clr_id) == hp, "R3", int'(clr_mask), m);
            mpred[cpu][hp] = mrun[cpu];
            mrun[cpu] = hp;
        end
        check_run(cpu, req);
        check_run(1 - cpu, "R10");
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic model_eoi(input int cpu, input int id);
        int t;
        if (mrun[cpu] == NONE) return;
        if (id == mrun[cpu]) begin
            mrun[cpu] = mpred[cpu][id];
        end else if (id < NI) begin
            t = mrun[cpu];
            while (mpred[cpu][t] != NONE) begin
                if (mpred[cpu][t] == id) begin
                    mpred[cpu][t] = mpred[cpu][id];
                    break;
                end
                t = mpred[cpu][t];
            end
        end
    endtask

    task automatic do_eoi(input int cpu, input logic [31:0] data, input string req);
        int id;
        bit s;
        id = int'(data[9:0]);
        s = (mrun[cpu] != NONE) && (id < NI) && !irq_edge[id % NI] && irq_en[id % NI]
            && irq_lvl[id % NI] && irq_tgt[(id % NI) * NC + cpu];
        eoi_req = 1'b1; eoi_cpu = 1'(cpu); eoi_data = data;
        @(posedge clk); #1;
        check(set_vld == s, "R5", int'(set_vld), int'(s));
        if (s) check(int'(set_mask) == (1 << cpu) && int'(set_id) == id, "R5", int'(set_mask), 1 << cpu);
        @(negedge clk);
        eoi_req = 1'b0;
        model_eoi(cpu, id);
        for (int w = 0; w < 40 && busy; w++) @(negedge clk);
        check(busy == 1'b0, "R9", int'(busy), 0);
        check_run(cpu, req);
        check_run(1 - cpu, "R10");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            mrun[c] = NONE;
            for (int k = 0; k < NI; k++) mpred[c][k] = NONE;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        check_run(0, "R4");
        check_run(1, "R4");
        check(busy == 1'b0 && ack_vld == 1'b0, "R4", int'(busy), 0);

        // R1: nothing pending, out-of-range candidate
        do_ack(0, NONE, 1'b0, "R1");
        do_ack(0, 12, 1'b0, "R1");
        // R4: completion while idle is ignored
        do_eoi(0, 32'd3, "R4");

        // R2/R3/R6/R7: every buried position, full nest on cpu 0
        for (int k = 0; k < NI - 1; k++) begin
            for (int i = 0; i < NI; i++) do_ack(0, i, 1'(i & 1), "R2");
            do_ack(0, 3, 1'b0, "R1");
            do_eoi(0, 32'(k), "R7");
            for (int p = 0; p < NI - 1; p++) do_eoi(0, 32'(mrun[0]), "R6");
            check(int'(run_id[9:0]) == NONE, "R6", int'(run_id[9:0]), NONE);
        end

        // R7/R8: out-of-range ID and upper data bits on cpu 1
        do_ack(1, 1, 1'b1, "R2");
        do_ack(1, 4, 1'b0, "R2");
        do_eoi(1, 32'd9, "R7");
        do_eoi(1, 32'd1023, "R7");
        do_eoi(1, 32'hFFFF_FC00 | 32'd1, "R8");
        do_eoi(1, 32'h1234_5400 | 32'd4, "R8");
        do_eoi(1, 32'd4, "R4");

        // R9: acknowledge from cpu 1 during a long walk on cpu 0
        for (int i = 0; i < NI; i++) do_ack(0, i, 1'b0, "R2");
        eoi_req = 1'b1; eoi_cpu = 1'b0; eoi_data = 32'd0;
        @(posedge clk); #1;
        @(negedge clk);
        eoi_req = 1'b0;
        model_eoi(0, 0);
        check(busy == 1'b1, "R9", int'(busy), 1);
        ack_req = 1'b1; ack_cpu = 1'b1; hp_id = 10'd0;
        @(posedge clk); #1;
        check(ack_vld == 1'b0, "R9", int'(ack_vld), 0);
        @(negedge clk);
        ack_req = 1'b0;
        for (int w = 0; w < 40 && busy; w++) @(negedge clk);
        check_run(1, "R9");
        for (int p = 0; p < NI - 1; p++) do_eoi(0, 32'(mrun[0]), "R7");

        // R5: re-pend qualification sweep on cpu 1, source 2
        for (int v = 0; v < 16; v++) begin
            irq_edge[2] = v[0]; irq_en[2] = v[1]; irq_lvl[2] = v[2];
            irq_tgt[2*NC+1] = v[3]; irq_tgt[2*NC+0] = !v[3];
            do_ack(1, 2, 1'b0, "R2");
            do_eoi(1, 32'd2, "R5");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule